// File: doc/BRIEF.md
# Four-Channel DMA Register Interface

This block is the processor-side register file of a four-channel DMA controller in the classic PC style. Software reaches it through a byte-wide I/O port with a 4-bit offset, a write strobe and a read strobe. Each channel keeps a 16-bit start address and a 16-bit transfer count, each in a base copy and a current copy, plus a mode byte. A shared command register, per-channel mask bits, software request bits and latched terminal-count flags are also held here.

All values are exported to a separate transfer engine. The engine writes back the current address and count of any channel, and it signals terminal count. The 16-bit registers sit behind a single byte offset each. One pointer flip-flop, shared by every channel, decides whether an access touches the low byte or the high byte. It flips after each such access. Software clears it before a two-byte sequence.

Top module: `dma_regif`

## Requirements
- R1: After reset, every channel register and mode byte is zero, all four mask bits are set, the command register is zero, the status byte reads 0x00 and the byte pointer selects the low byte.
- R2: Channel n's address register is at offset 2n and its count register at offset 2n+1. A write stores data[7:0] into the low byte when the pointer is clear, or into the high byte when it is set, and loads that byte into both the base copy and the current copy.
- R3: A single pointer is shared by all channels. Every read or write of offsets 0x0 to 0x7 flips it. Any write to offset 0xC clears it.
- R4: A read of offsets 0x0 to 0x7 returns the selected byte of the current copy. A one-cycle pulse on eng_load[n] replaces channel n's current address and count with eng_addr and eng_cnt, and leaves the base copies unchanged.
- R5: A write to offset 0xA selects a channel with data bits 1:0. Data bit 2 = 1 sets that channel's mask bit, and 0 clears it. The other mask bits keep their values.
- R6: A write to offset 0xF loads data bits 3:0 as the mask bits of channels 0 to 3. A write to offset 0xE clears all four mask bits.
- R7: A write to offset 0xB stores the whole data byte as the mode byte of the channel named by data bits 1:0. Bit 4 of the mode byte is the auto-initialize flag.
- R8: A write to offset 0x8 loads the command register, which appears on cmd_q one cycle later.
- R9: A read of offset 0x8 returns the status byte. Bits 3:0 are the terminal-count flags, set by eng_tc[n]. Bits 7:4 are the software request bits of channels 0 to 3. A write to offset 0x9 sets the request bit of channel data[1:0] to data bit 2.
- R10: The terminal-count flags are cleared by the status read that returns them. A terminal-count pulse in the same cycle as that read wins.
- R11: A write to offset 0xD clears the pointer, the command register, the request bits and the terminal-count flags, and sets all four mask bits. Channel address, count and mode registers keep their values.
- R12: Reads of offsets 0x9 to 0xF return 0x00 and do not move the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_off | input | 4 | Register offset |
| io_wr | input | 1 | Write strobe, one access per cycle |
| io_rd | input | 1 | Read strobe, one access per cycle |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, valid in the strobe cycle |
| eng_load | input | 4 | Per-channel load of current address and count |
| eng_addr | input | 64 | Current addresses from the engine, channel n at [16n+15:16n] |
| eng_cnt | input | 64 | Current counts from the engine, same packing |
| eng_tc | input | 4 | Terminal-count pulses per channel |
| ch_base_addr | output | 64 | Base addresses |
| ch_base_cnt | output | 64 | Base counts |
| ch_cur_addr | output | 64 | Current addresses |
| ch_cur_cnt | output | 64 | Current counts |
| ch_mode | output | 32 | Mode bytes, channel n at [8n+7:8n] |
| ch_mask | output | 4 | Mask bits, bit n for channel n |
| cmd_q | output | 8 | Command register |

## Verification
Long random sequences mix byte writes and reads across all four channels, with pointer clears placed at random points. These show whether the shared pointer advances on both reads and writes and whether the two halves land in the right byte. Random mask, mode, request and command writes with arbitrary channel fields separate the single-channel form, the all-channels form and the clear-all form. Directed engine loads and terminal-count pulses, including one that arrives in the same cycle as a status read, separate the current copies from the base copies and show that setting a flag takes priority over clearing it. Master clear is issued in the middle of traffic to show which state it resets and which it preserves.

// File: rtl/dma_regif_pkg.sv
package dma_regif_pkg;

    localparam int NCH   = 4;
    localparam int AW    = 16;
    localparam int DW    = 8;
    localparam int OFFW  = 4;
    localparam int CHW   = $clog2(NCH);
    localparam int NCHOFF = 2 * NCH;

    typedef enum logic [OFFW-1:0] {
        OFF_CMD     = 4'h8,
        OFF_REQ     = 4'h9,
        OFF_MASK1   = 4'hA,
        OFF_MODE    = 4'hB,
        OFF_PTRCLR  = 4'hC,
        OFF_MCLR    = 4'hD,
        OFF_UNMASK  = 4'hE,
        OFF_MASKALL = 4'hF
    } ctl_off_e;

    typedef struct packed {
        logic            wr;
        logic            rd;
        logic [OFFW-1:0] off;
        logic [DW-1:0]   data;
    } bus_req_t;

    typedef struct packed {
        logic [AW-1:0] base_addr;
        logic [AW-1:0] cur_addr;
        logic [AW-1:0] base_cnt;
        logic [AW-1:0] cur_cnt;
        logic [DW-1:0] mode;
    } chan_regs_t;

    function automatic logic is_chan_off(input logic [OFFW-1:0] off);
        return int'(off) < NCHOFF;
    endfunction

    function automatic logic [DW-1:0] pick_byte(input logic [AW-1:0] v, input logic hi);
        return hi ? v[AW-1:DW] : v[DW-1:0];
    endfunction

    function automatic logic [AW-1:0] put_byte(input logic [AW-1:0] v, input logic hi,
                                               input logic [DW-1:0] b);
        logic [AW-1:0] r;
        r = v;
        if (hi) r[AW-1:DW] = b;
        else    r[DW-1:0]  = b;
        return r;
    endfunction

endpackage

// File: rtl/dma_byteptr.sv
module dma_byteptr
    import dma_regif_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  bus_req_t req,
    output logic     ptr_q
);
    logic toggle;
    logic clr;

    assign toggle = (req.wr || req.rd) && is_chan_off(req.off);
    assign clr    = req.wr && (req.off == OFF_PTRCLR || req.off == OFF_MCLR);

    always_ff @(posedge clk) begin
        if (rst || clr)  ptr_q <= 1'b0;
        else if (toggle) ptr_q <= ~ptr_q;
    end
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
    import dma_regif_pkg::*;
#(
    parameter int IDX = 0
) (
    input  logic          clk,
    input  logic          rst,
    input  bus_req_t      req,
    input  logic          ptr,
    input  logic          eng_load,
    input  logic [AW-1:0] eng_addr,
    input  logic [AW-1:0] eng_cnt,
    output chan_regs_t    regs
);
    localparam logic [OFFW-1:0] ADDR_OFF = OFFW'(2 * IDX);
    localparam logic [OFFW-1:0] CNT_OFF  = OFFW'(2 * IDX + 1);
    localparam logic [CHW-1:0]  SEL      = CHW'(IDX);

    logic wr_addr, wr_cnt, wr_mode;

    assign wr_addr = req.wr && req.off == ADDR_OFF;
    assign wr_cnt  = req.wr && req.off == CNT_OFF;
    assign wr_mode = req.wr && req.off == OFF_MODE && req.data[CHW-1:0] == SEL;

    always_ff @(posedge clk) begin
        if (rst) begin
            regs <= '0;
        end else begin
            if (wr_addr) begin
                regs.base_addr <= put_byte(regs.base_addr, ptr, req.data);
                regs.cur_addr  <= put_byte(regs.cur_addr,  ptr, req.data);
            end else if (eng_load) begin
                regs.cur_addr  <= eng_addr;
            end
            if (wr_cnt) begin
                regs.base_cnt  <= put_byte(regs.base_cnt, ptr, req.data);
                regs.cur_cnt   <= put_byte(regs.cur_cnt,  ptr, req.data);
            end else if (eng_load) begin
                regs.cur_cnt   <= eng_cnt;
            end
            if (wr_mode) regs.mode <= req.data;
        end
    end
endmodule

// File: rtl/dma_ctrl_regs.sv
module dma_ctrl_regs
    import dma_regif_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  bus_req_t       req,
    input  logic [NCH-1:0] eng_tc,
    output logic [DW-1:0]  cmd_q,
    output logic [NCH-1:0] mask_q,
    output logic [DW-1:0]  status
);
    logic [NCH-1:0] tc_q;
    logic [NCH-1:0] swreq_q;
    logic           mclr, stat_rd;

    assign mclr    = req.wr && req.off == OFF_MCLR;
    assign stat_rd = req.rd && req.off == OFF_CMD;

    always_ff @(posedge clk) begin
        if (rst || mclr) begin
            cmd_q   <= '0;
            mask_q  <= '1;
            swreq_q <= '0;
        end else if (req.wr) begin
            case (req.off)
                OFF_CMD:     cmd_q <= req.data;
                OFF_REQ:     swreq_q[req.data[CHW-1:0]] <= req.data[2];
                OFF_MASK1:   mask_q[req.data[CHW-1:0]]  <= req.data[2];
                OFF_UNMASK:  mask_q <= '0;
                OFF_MASKALL: mask_q <= req.data[NCH-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst || mclr) tc_q <= '0;
        else             tc_q <= (stat_rd ? '0 : tc_q) | eng_tc;
    end

    assign status = {swreq_q, tc_q};
endmodule

// File: rtl/dma_regif.sv
module dma_regif
    import dma_regif_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [OFFW-1:0]    io_off,
    input  logic               io_wr,
    input  logic               io_rd,
    input  logic [DW-1:0]      io_wdata,
    output logic [DW-1:0]      io_rdata,
    input  logic [NCH-1:0]     eng_load,
    input  logic [NCH*AW-1:0]  eng_addr,
    input  logic [NCH*AW-1:0]  eng_cnt,
    input  logic [NCH-1:0]     eng_tc,
    output logic [NCH*AW-1:0]  ch_base_addr,
    output logic [NCH*AW-1:0]  ch_base_cnt,
    output logic [NCH*AW-1:0]  ch_cur_addr,
    output logic [NCH*AW-1:0]  ch_cur_cnt,
    output logic [NCH*DW-1:0]  ch_mode,
    output logic [NCH-1:0]     ch_mask,
    output logic [DW-1:0]      cmd_q
);
    bus_req_t   req;
    logic       ptr_q;
    logic [DW-1:0] status;
    chan_regs_t chans [NCH];

    assign req = '{wr: io_wr, rd: io_rd, off: io_off, data: io_wdata};

    dma_byteptr u_ptr (
        .clk   (clk),
        .rst   (rst),
        .req   (req),
        .ptr_q (ptr_q)
    );

    for (genvar n = 0; n < NCH; n++) begin : g_ch
        dma_chan_regs #(.IDX(n)) u_ch (
            .clk      (clk),
            .rst      (rst),
            .req      (req),
            .ptr      (ptr_q),
            .eng_load (eng_load[n]),
            .eng_addr (eng_addr[n*AW +: AW]),
            .eng_cnt  (eng_cnt[n*AW +: AW]),
            .regs     (chans[n])
        );
        assign ch_base_addr[n*AW +: AW] = chans[n].base_addr;
        assign ch_base_cnt[n*AW +: AW]  = chans[n].base_cnt;
        assign ch_cur_addr[n*AW +: AW]  = chans[n].cur_addr;
        assign ch_cur_cnt[n*AW +: AW]   = chans[n].cur_cnt;
        assign ch_mode[n*DW +: DW]      = chans[n].mode;
    end

    dma_ctrl_regs u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .req    (req),
        .eng_tc (eng_tc),
        .cmd_q  (cmd_q),
        .mask_q (ch_mask),
        .status (status)
    );

    always_comb begin
        io_rdata = '0;
        if (is_chan_off(io_off)) begin
            for (int n = 0; n < NCH; n++) begin
                if (int'(io_off[OFFW-1:1]) == n)
                    io_rdata = io_off[0] ? pick_byte(chans[n].cur_cnt, ptr_q)
                                         : pick_byte(chans[n].cur_addr, ptr_q);
            end
        end else if (io_off == OFF_CMD) begin
            io_rdata = status;
        end
    end
endmodule

// File: rtl/dma_regif_chk.sv
module dma_regif_chk
    import dma_regif_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [OFFW-1:0]   io_off,
    input logic              io_wr,
    input logic              io_rd,
    input logic [DW-1:0]     io_wdata,
    input logic              ptr_q,
    input logic [NCH-1:0]    ch_mask,
    input logic [DW-1:0]     cmd_q,
    input logic [NCH*AW-1:0] ch_base_addr,
    input logic [NCH*AW-1:0] ch_base_cnt
);
    // R3
    ptr_clear_chk: assert property (@(posedge clk) disable iff (rst)
        io_wr && io_off == OFF_PTRCLR |=> !ptr_q);
    // R3
    ptr_toggle_chk: assert property (@(posedge clk) disable iff (rst)
        (io_wr || io_rd) && int'(io_off) < NCHOFF |=> ptr_q != $past(ptr_q));
    // R5
    mask_single_chk: assert property (@(posedge clk) disable iff (rst)
        io_wr && io_off == OFF_MASK1 |=> ch_mask[$past(io_wdata[CHW-1:0])] == $past(io_wdata[2]));
    // R6
    mask_all_chk: assert property (@(posedge clk) disable iff (rst)
        io_wr && io_off == OFF_MASKALL |=> ch_mask == $past(io_wdata[NCH-1:0]));
    // R6
    unmask_chk: assert property (@(posedge clk) disable iff (rst)
        io_wr && io_off == OFF_UNMASK |=> ch_mask == '0);
    // R8
    cmd_load_chk: assert property (@(posedge clk) disable iff (rst)
        io_wr && io_off == OFF_CMD |=> cmd_q == $past(io_wdata));
    // R11
    mclr_chk: assert property (@(posedge clk) disable iff (rst)
        io_wr && io_off == OFF_MCLR |=> ch_mask == '1 && cmd_q == '0 && !ptr_q);
    // R4
    base_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(io_wr && int'(io_off) < NCHOFF) |=> $stable(ch_base_addr) && $stable(ch_base_cnt));
endmodule

bind dma_regif dma_regif_chk chk_i (
    .clk          (clk),
    .rst          (rst),
    .io_off       (io_off),
    .io_wr        (io_wr),
    .io_rd        (io_rd),
    .io_wdata     (io_wdata),
    .ptr_q        (ptr_q),
    .ch_mask      (ch_mask),
    .cmd_q        (cmd_q),
    .ch_base_addr (ch_base_addr),
    .ch_base_cnt  (ch_base_cnt)
);

// File: tb/dma_regif_tb_top.sv
module dma_regif_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  io_off = '0;
    logic        io_wr = 1'b0, io_rd = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic [3:0]  eng_load = '0;
    logic [63:0] eng_addr = '0, eng_cnt = '0;
    logic [3:0]  eng_tc = '0;
    logic [63:0] ch_base_addr, ch_base_cnt, ch_cur_addr, ch_cur_cnt;
    logic [31:0] ch_mode;
    logic [3:0]  ch_mask;
    logic [7:0]  cmd_q;

    int total = 0, bad = 0;

    always #10 clk = ~clk;

    dma_regif dut_i (
        .clk(clk), .rst(rst), .io_off(io_off), .io_wr(io_wr), .io_rd(io_rd),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .eng_load(eng_load),
        .eng_addr(eng_addr), .eng_cnt(eng_cnt), .eng_tc(eng_tc),
        .ch_base_addr(ch_base_addr), .ch_base_cnt(ch_base_cnt),
        .ch_cur_addr(ch_cur_addr), .ch_cur_cnt(ch_cur_cnt),
        .ch_mode(ch_mode), .ch_mask(ch_mask), .cmd_q(cmd_q)
    );

    // bench model
    logic [15:0] m_ba[4], m_ca[4], m_bc[4], m_cc[4];
    logic [7:0]  m_mode[4];
    logic [3:0]  m_mask, m_tc, m_req;
    logic [7:0]  m_cmd;
    logic        m_ptr;

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] setb(input logic [15:0] v, input logic hi, input logic [7:0] b);
        return hi ? {b, v[7:0]} : {v[15:8], b};
    endfunction

    task automatic model_reset();
        for (int n = 0; n < 4; n++) begin
            m_ba[n] = 0; m_ca[n] = 0; m_bc[n] = 0; m_cc[n] = 0; m_mode[n] = 0;
        end
        m_mask = 4'hF; m_tc = 0; m_req = 0; m_cmd = 0; m_ptr = 0;
    endtask

    task automatic bw(input logic [3:0] off, input logic [7:0] d);
        int ch;
        @(negedge clk);
        io_off = off; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
        ch = int'(off) >> 1;
        if (off < 4'h8) begin
            if (off[0]) begin m_bc[ch] = setb(m_bc[ch], m_ptr, d); m_cc[ch] = setb(m_cc[ch], m_ptr, d); end
            else        begin m_ba[ch] = setb(m_ba[ch], m_ptr, d); m_ca[ch] = setb(m_ca[ch], m_ptr, d); end
            m_ptr = ~m_ptr;
        end else begin
            case (off)
                4'h8: m_cmd = d;
                4'h9: m_req[d[1:0]] = d[2];
                4'hA: m_mask[d[1:0]] = d[2];
                4'hB: m_mode[d[1:0]] = d;
                4'hC: m_ptr = 1'b0;
                4'hD: begin m_ptr = 0; m_cmd = 0; m_req = 0; m_tc = 0; m_mask = 4'hF; end
                4'hE: m_mask = 4'h0;
                default: m_mask = d[3:0];
            endcase
        end
    endtask

    task automatic br(input logic [3:0] off, input string tag);
        logic [7:0] exp;
        int ch;
        ch = int'(off) >> 1;
        exp = 8'h00;
        if (off < 4'h8) begin
            if (off[0]) exp = m_ptr ? m_cc[ch][15:8] : m_cc[ch][7:0];
            else        exp = m_ptr ? m_ca[ch][15:8] : m_ca[ch][7:0];
        end else if (off == 4'h8) begin
            exp = {m_req, m_tc};
        end
        @(negedge clk);
        io_off = off; io_rd = 1'b1;
        #2;
        check(tag, 64'(io_rdata), 64'(exp));
        @(negedge clk);
        io_rd = 1'b0;
        if (off < 4'h8) m_ptr = ~m_ptr;
        if (off == 4'h8) m_tc = 0;
    endtask

    task automatic chk_ports();
        for (int n = 0; n < 4; n++) begin
            check("R2 base addr port", 64'(ch_base_addr[n*16 +: 16]), 64'(m_ba[n]));
            check("R2 base count port", 64'(ch_base_cnt[n*16 +: 16]), 64'(m_bc[n]));
            check("R4 current addr port", 64'(ch_cur_addr[n*16 +: 16]), 64'(m_ca[n]));
            check("R7 mode port", 64'(ch_mode[n*8 +: 8]), 64'(m_mode[n]));
        end
        check("R5/R6 mask port", 64'(ch_mask), 64'(m_mask));
        check("R8 command port", 64'(cmd_q), 64'(m_cmd));
    endtask

    task automatic eng_pulse(input logic [3:0] ld, input logic [3:0] tc, input logic [15:0] a,
                             input logic [15:0] c);
        @(negedge clk);
        eng_load = ld; eng_tc = tc;
        eng_addr = {4{a}}; eng_cnt = {4{c}};
        @(negedge clk);
        eng_load = 0; eng_tc = 0;
        for (int n = 0; n < 4; n++) if (ld[n]) begin m_ca[n] = a; m_cc[n] = c; end
        m_tc = m_tc | tc;
    endtask

    initial begin
        #(20 * 150000);
        bad++; total++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check("R1 mask after reset", 64'(ch_mask), 64'hF);
        check("R1 cmd after reset", 64'(cmd_q), 64'h0);
        check("R1 base addr after reset", ch_base_addr, 64'h0);
        br(4'h8, "R1 status after reset");
        br(4'h0, "R1 pointer low after reset");

        // R2 R3 directed: shared pointer across channels
        bw(4'hC, 8'h00);
        bw(4'h2, 8'h34);           // ch1 addr low
        bw(4'h5, 8'hAB);           // ch2 count high: pointer shared
        chk_ports();
        br(4'h2, "R3 shared pointer: low byte read");
        br(4'h2, "R3 shared pointer: high byte read");
        bw(4'hC, 8'h00);
        br(4'h5, "R3 cleared pointer selects low byte");

        // R4 engine load leaves base
        bw(4'hC, 8'h00);
        bw(4'h0, 8'h11); bw(4'h0, 8'h22);
        bw(4'h1, 8'hFF); bw(4'h1, 8'hFF);
        eng_pulse(4'b0001, 4'b0000, 16'h2300, 16'hFFFF);
        chk_ports();
        br(4'h0, "R4 current addr low after engine load");
        br(4'h0, "R4 current addr high after engine load");
        eng_pulse(4'b0001, 4'b0000, 16'h5A5A, 16'h0007);
        br(4'h1, "R4 current count low");
        br(4'h1, "R4 current count high");
        chk_ports();

        // R9 R10 terminal count and status read
        eng_pulse(4'b0000, 4'b0101, 16'h0, 16'h0);
        bw(4'h9, 8'h07);           // request ch3
        br(4'h8, "R9 status with tc and request");
        br(4'h8, "R10 tc flags cleared by status read");
        @(negedge clk);
        io_off = 4'h8; io_rd = 1'b1; eng_tc = 4'b0010;
        #2;
        check("R9 status during racing tc", 64'(io_rdata), 64'({m_req, 4'h0}));
        @(negedge clk);
        io_rd = 1'b0; eng_tc = 0;
        m_tc = 4'b0010;
        br(4'h8, "R10 racing tc wins over clear");

        // R11 master clear keeps channel regs
        bw(4'h8, 8'h5C);
        bw(4'hE, 8'h00);
        bw(4'h4, 8'h99);
        bw(4'hD, 8'h00);
        chk_ports();
        br(4'h8, "R11 status after master clear");
        br(4'h0, "R11 channel reg kept, pointer low");

        // R12 control reads return zero and keep pointer
        bw(4'hC, 8'h00);
        for (int o = 9; o < 16; o++) br(4'(o), "R12 control offset read");
        br(4'h0, "R12 pointer unmoved by control reads");

        // random phase
        for (int i = 0; i < 4000; i++) begin
            int r;
            r = int'($urandom % 16);
            if (r < 5)       bw(4'($urandom % 8), 8'($urandom));
            else if (r < 9)  br(4'($urandom % 16), "R2/R3/R4 random readback");
            else if (r == 9) bw(4'hC, 8'h00);
            else if (r == 10) bw(4'hA, 8'($urandom));
            else if (r == 11) bw(4'($urandom % 2 == 0 ? 14 : 15), 8'($urandom));
            else if (r == 12) bw(4'hB, 8'($urandom));
            else if (r == 13) bw(4'($urandom % 2 == 0 ? 8 : 9), 8'($urandom));
            else if (r == 14) eng_pulse(4'($urandom), 4'($urandom), 16'($urandom), 16'($urandom));
            else if ($urandom % 8 == 0) bw(4'hD, 8'h00);
            else br(4'h8, "R9/R10 random status read");
            if (i % 4 == 0) chk_ports();
        end
        chk_ports();

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule